// File: doc/BRIEF.md
# Programmed-I/O Floppy Controller Sequencer

This block is the host-side command engine of a single-density floppy controller. A host reaches it through two words. One is a control/status word and the other is an 8-bit data word. The host starts a function by writing the control word with its start bit set. After that, every byte the function needs or produces passes through the data word, one at a time. The transfer-request flag (TR) paces each byte. Completion is reported with a done flag, an optional interrupt and an error summary.

The block owns a sector buffer of 128 bytes. Fill and empty functions move that buffer to and from the host. Read and write functions first collect a sector byte and then a track byte from the host. They then move the whole buffer to or from a storage back end, one byte per request/acknowledge handshake. An initialise request clears the controller and then loads track 1, sector 1 of drive 0 into the buffer without any further host action.

Top module: `fdc_pio_seq`

## Requirements
- R1: After `rst_n` is low at a clock edge, the control word reads 0, the data word reads 0, and `irq` and `mem_req` are low.
- R2: A control-word read shows only error (bit 15), TR (bit 7), interrupt enable (bit 6) and done (bit 5); all other bits read 0. A start request (bit 0) is accepted only while idle. Accepting it keeps function (bits 3:1), drive (bit 4) and enable, and clears done, error, TR and `irq`. While busy, a control-word write with bit 0 set only changes the enable.
- R3: Function 0 (fill) raises TR at once. Each accepted data-word byte is stored at the next buffer position. After byte 128 the function completes.
- R4: Function 1 (empty) presents buffer bytes 0..127 in order in the data word with TR set. A data-word read while TR is set clears TR and advances. After 128 reads the function completes.
- R5: Functions 2 (write), 3 (read) and 6 (write with deleted mark) raise TR for a sector byte, keeping its low 7 bits, and then for a track byte, keeping all 8 bits. Only then do they issue `mem_req` with `mem_drive`, `mem_track` and `mem_sector` for indexes 0..127. Read stores `mem_rdata` into the buffer. Writes present the buffer on `mem_wdata`.
- R6: On completion the controller goes idle and sets done, with TR clear. It raises `irq` if enable is set, and sets error if the new error code is nonzero. It loads the status byte into the data word. The status byte's drive-ready bit 0x80 equals `drv_present` of the selected drive.
- R7: Before any medium access, the read/write checks run in this priority order, each recording an error code: drive absent gives 0x48, track 77 or above gives 0x20, sector 0 or above 26 gives 0x38, and a write to a protected drive gives 0x40 and sets status bit 0x08. No `mem_req` is issued on error.
- R8: A successful function 6 sets status bit 0x40. Starting any of functions 2, 3 or 6 clears every status bit except 0x04.
- R9: Functions 4 and 5 complete with the status byte in the data word. Function 7 completes with the stored error code in the data word. It neither changes that code nor sets error.
- R10: Setting bit 14 of the control word clears all registers. The controller then reads drive 0, track 1, sector 1 into the buffer and completes with status bit 0x04. If drive 0 is absent, it completes at once with 0x04, no drive-ready bit and error code 0x08.
- R11: A data-word write is ignored while busy with TR clear, and a high-lane byte write to the data word is always ignored. While idle, a data-word write simply stores the byte.
- R12: A control-word write that starts nothing changes only the enable. Clearing the enable drops `irq`. Setting it while done is already set raises `irq`.
- R13: A byte write to the control word merges `bus_wdata[7:0]` into the byte chosen by `bus_hi` (1 = high byte). The merged word is then treated as a full write, so a high-byte value of 0x40 initialises.
- R14: After a handshake byte is accepted, TR stays low for exactly `TR_DLY` clock edges. It is raised again at the `TR_DLY`-th edge after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Word select: 0 control/status, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_byte | input | 1 | Byte-lane write |
| bus_hi | input | 1 | Byte lane select for byte writes, 1 = high |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Read data of the selected word |
| irq | output | 1 | Interrupt request level |
| drv_present | input | 2 | Per-drive medium present |
| drv_wprot | input | 2 | Per-drive write protect |
| mem_req | output | 1 | Back-end byte request |
| mem_we | output | 1 | Request is a write |
| mem_drive | output | 1 | Drive of the request |
| mem_track | output | 8 | Track of the request |
| mem_sector | output | 7 | Sector of the request |
| mem_idx | output | 7 | Byte index within the sector |
| mem_wdata | output | 8 | Byte written to the back end |
| mem_rdata | input | 8 | Byte returned by the back end |
| mem_ack | input | 1 | Back end completes the current byte |

## Verification
The hardest case to reach is a data-word write that lands while the controller is busy and TR is low. With a TR delay of one cycle, that window lasts a single clock. The bench reaches it by writing two data bytes on back-to-back cycles during a fill. It then empties the buffer to prove that the second byte never entered it. The error priority and the protect bit depend on drive-level inputs. The bench toggles the present and protect inputs between commands, and it counts back-end acknowledges to show that rejected commands never touch the medium.

// File: rtl/fdc_pkg.sv
// Shared encodings of the floppy sequencer: states, function codes,
// control-word bit positions, status bits and error codes.
package fdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_FILL, ST_EMPTY, ST_SECT, ST_TRK, ST_XFER, ST_CMD
    } fdc_state_e;

    localparam logic [2:0] FN_FILL  = 3'd0;
    localparam logic [2:0] FN_EMPTY = 3'd1;
    localparam logic [2:0] FN_WRITE = 3'd2;
    localparam logic [2:0] FN_READ  = 3'd3;
    localparam logic [2:0] FN_WDEL  = 3'd6;
    localparam logic [2:0] FN_CODE  = 3'd7;

    localparam int CB_GO   = 0;
    localparam int CB_DRV  = 4;
    localparam int CB_DONE = 5;
    localparam int CB_IE   = 6;
    localparam int CB_TR   = 7;
    localparam int CB_INIT = 14;
    localparam int CB_ERR  = 15;

    localparam logic [7:0] SB_INITOK = 8'h04;
    localparam logic [7:0] SB_PROT   = 8'h08;
    localparam logic [7:0] SB_DELMK  = 8'h40;

    localparam logic [7:0] EC_NODRV  = 8'h48;
    localparam logic [7:0] EC_TRACK  = 8'h20;
    localparam logic [7:0] EC_SECTOR = 8'h38;
    localparam logic [7:0] EC_PROT   = 8'h40;
    localparam logic [7:0] EC_INITNO = 8'h08;
endpackage

// File: rtl/fdc_sector_buf.sv
// Sector byte store. One synchronous write port and one asynchronous
// read port. Assumes writer and reader never need the same cycle.
module fdc_sector_buf #(
    parameter int BYTES = 128,
    localparam int IW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [BYTES];

    // store one byte per enabled cycle
    always_ff @(posedge clk) begin
        if (we) mem_q[widx] <= wdata;
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/fdc_tr_timer.sv
// Handshake pacing timer. A start pulse arms it, and fire is high in the
// cycle before the DLY-th edge after start. Assumes DLY >= 1.
module fdc_tr_timer #(
    parameter int DLY = 1,
    localparam int CW = $clog2(DLY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic fire
);
    logic [CW-1:0] cnt_q;

    // load on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || clear)   cnt_q <= '0;
        else if (start)        cnt_q <= CW'(DLY);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign fire = (cnt_q == CW'(1));
endmodule

// File: rtl/fdc_addr_check.sv
// Validates a read/write request before the medium is touched and picks
// the error code by fixed priority: drive, track, sector, protection.
module fdc_addr_check
    import fdc_pkg::*;
#(
    parameter int TRACKS  = 77,
    parameter int SECTORS = 26
) (
    input  logic       present,
    input  logic       wprot,
    input  logic       is_write,
    input  logic [7:0] track,
    input  logic [6:0] sector,
    output logic [7:0] code,
    output logic       prot_hit
);
    // priority-ordered rejection
    always_comb begin
        code     = 8'h00;
        prot_hit = 1'b0;
        if (!present)                                        code = EC_NODRV;
        else if (track >= 8'(TRACKS))                        code = EC_TRACK;
        else if (sector == '0 || sector > 7'(SECTORS))       code = EC_SECTOR;
        else if (is_write && wprot) begin
            code     = EC_PROT;
            prot_hit = 1'b1;
        end
    end
endmodule

// File: rtl/fdc_pio_seq.sv
// Floppy controller command sequencer behind a two-word programmed-I/O
// window. It paces host bytes with TR, owns the sector buffer and drives a
// byte-wide request/acknowledge port to storage. Assumes one bus access per
// cycle at most, and a back end that holds mem_rdata valid with mem_ack.
module fdc_pio_seq
    import fdc_pkg::*;
#(
    parameter int BYTES   = 128,
    parameter int TRACKS  = 77,
    parameter int SECTORS = 26,
    parameter int TR_DLY  = 1,
    localparam int IW = $clog2(BYTES),
    localparam int PW = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_byte,
    input  logic          bus_hi,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          irq,
    input  logic [1:0]    drv_present,
    input  logic [1:0]    drv_wprot,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_drive,
    output logic [7:0]    mem_track,
    output logic [6:0]    mem_sector,
    output logic [IW-1:0] mem_idx,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_ack
);
    fdc_state_e state_q;
    logic [2:0] func_q;
    logic       drv_q, ie_q, done_q, tr_q, err_q, irq_q, boot_q;
    logic [7:0] dbr_q, esr_q, ecode_q, trk_q;
    logic [6:0] sec_q;
    logic [PW-1:0] ptr_q;

    logic [15:0] csr_cur, csr_new;
    logic        csr_wr, init_req, go_req, busy, tick, tstart;
    logic        db_take, step_wr, rd_take;
    logic        buf_we;
    logic [7:0]  buf_wd, buf_rd;
    logic [7:0]  chk_code;
    logic        chk_prot;
    logic        fin_en, fin_keep;
    logic [7:0]  fin_flags, fin_code, fin_esr;
    logic        unused_bits;

    assign busy    = (state_q != ST_IDLE);
    assign csr_cur = {err_q, 7'b0, tr_q, ie_q, done_q, drv_q, func_q, 1'b0};

    // merge byte-lane writes into the live control word
    always_comb begin
        if (!bus_byte)   csr_new = bus_wdata;
        else if (bus_hi) csr_new = {bus_wdata[7:0], csr_cur[7:0]};
        else             csr_new = {csr_cur[15:8], bus_wdata[7:0]};
    end
    assign unused_bits = ^{csr_new[15], csr_new[13:7], csr_new[5], bus_wdata[15:8]};

    assign csr_wr   = bus_wr && !bus_sel;
    assign init_req = csr_wr && csr_new[CB_INIT];
    assign go_req   = csr_wr && !csr_new[CB_INIT] && csr_new[CB_GO] && !busy;
    assign db_take  = bus_wr && bus_sel && !(bus_byte && bus_hi) && (!busy || tr_q);
    assign step_wr  = db_take && busy && (state_q != ST_EMPTY);
    assign rd_take  = bus_rd && bus_sel && (state_q == ST_EMPTY) && tr_q;
    assign tstart   = step_wr || rd_take ||
                      (go_req && (csr_new[3:1] == FN_EMPTY || csr_new[3:1] == 3'd4 ||
                                  csr_new[3:1] == 3'd5 || csr_new[3:1] == FN_CODE));

    fdc_tr_timer #(.DLY(TR_DLY)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clear(init_req), .start(tstart), .fire(tick)
    );

    assign buf_we = (state_q == ST_FILL && step_wr) ||
                    (state_q == ST_XFER && mem_ack && !mem_we);
    assign buf_wd = (state_q == ST_FILL) ? bus_wdata[7:0] : mem_rdata;

    fdc_sector_buf #(.BYTES(BYTES)) buf_i (
        .clk(clk), .we(buf_we), .widx(ptr_q[IW-1:0]), .wdata(buf_wd),
        .ridx(ptr_q[IW-1:0]), .rdata(buf_rd)
    );

    fdc_addr_check #(.TRACKS(TRACKS), .SECTORS(SECTORS)) chk_i (
        .present(drv_present[drv_q]), .wprot(drv_wprot[drv_q]),
        .is_write(func_q != FN_READ), .track(dbr_q), .sector(sec_q),
        .code(chk_code), .prot_hit(chk_prot)
    );

    // decide whether this cycle finishes the command and with what result
    always_comb begin
        fin_en = 1'b0; fin_keep = 1'b0; fin_flags = 8'h00; fin_code = 8'h00;
        unique case (state_q)
            ST_FILL, ST_EMPTY: fin_en = tick && (ptr_q == PW'(BYTES));
            ST_TRK: if (tick && chk_code != 8'h00) begin
                fin_en    = 1'b1;
                fin_code  = chk_code;
                fin_flags = chk_prot ? (SB_PROT | ((func_q == FN_WDEL) ? SB_DELMK : 8'h00)) : 8'h00;
            end
            ST_XFER: if (mem_ack && ptr_q == PW'(BYTES - 1)) begin
                fin_en    = 1'b1;
                fin_flags = boot_q ? SB_INITOK : ((func_q == FN_WDEL) ? SB_DELMK : 8'h00);
            end
            ST_CMD: begin
                fin_en   = tick;
                fin_keep = (func_q == FN_CODE);
            end
            default: ;
        endcase
        fin_esr = ((esr_q | fin_flags) & 8'h7F) | {drv_present[drv_q], 7'b0};
    end

    // command state machine and host-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; func_q <= '0; drv_q <= 1'b0; ie_q <= 1'b0;
            done_q <= 1'b0; tr_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0;
            boot_q <= 1'b0; dbr_q <= '0; esr_q <= '0; ecode_q <= '0;
            trk_q <= '0; sec_q <= '0; ptr_q <= '0;
        end else if (init_req) begin
            func_q <= FN_READ; drv_q <= 1'b0; ie_q <= 1'b0; tr_q <= 1'b0;
            irq_q <= 1'b0; trk_q <= 8'd1; sec_q <= 7'd1; ptr_q <= '0;
            if (drv_present[0]) begin
                state_q <= ST_XFER; boot_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0;
                dbr_q <= '0; esr_q <= '0; ecode_q <= '0;
            end else begin
                state_q <= ST_IDLE; boot_q <= 1'b0; done_q <= 1'b1; err_q <= 1'b1;
                dbr_q <= SB_INITOK; esr_q <= SB_INITOK; ecode_q <= EC_INITNO;
            end
        end else if (go_req) begin
            func_q <= csr_new[3:1]; drv_q <= csr_new[CB_DRV]; ie_q <= csr_new[CB_IE];
            done_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0; boot_q <= 1'b0; ptr_q <= '0;
            tr_q <= 1'b0;
            unique case (csr_new[3:1])
                FN_FILL:  begin state_q <= ST_FILL; tr_q <= 1'b1; end
                FN_EMPTY: state_q <= ST_EMPTY;
                FN_WRITE, FN_READ, FN_WDEL: begin
                    state_q <= ST_SECT; tr_q <= 1'b1; esr_q <= esr_q & SB_INITOK;
                end
                default:  state_q <= ST_CMD;
            endcase
        end else begin
            if (db_take) dbr_q <= bus_wdata[7:0];
            unique case (state_q)
                ST_FILL: begin
                    if (step_wr) begin ptr_q <= ptr_q + 1'b1; tr_q <= 1'b0; end
                    if (tick && ptr_q != PW'(BYTES)) tr_q <= 1'b1;
                end
                ST_EMPTY: begin
                    if (rd_take) tr_q <= 1'b0;
                    if (tick && ptr_q != PW'(BYTES)) begin
                        dbr_q <= buf_rd; ptr_q <= ptr_q + 1'b1; tr_q <= 1'b1;
                    end
                end
                ST_SECT: begin
                    if (step_wr) tr_q <= 1'b0;
                    if (tick) begin sec_q <= dbr_q[6:0]; tr_q <= 1'b1; state_q <= ST_TRK; end
                end
                ST_TRK: begin
                    if (step_wr) tr_q <= 1'b0;
                    if (tick) begin
                        trk_q <= dbr_q;
                        if (chk_code == 8'h00) state_q <= ST_XFER;
                    end
                end
                ST_XFER: if (mem_ack) ptr_q <= ptr_q + 1'b1;
                default: ;
            endcase
            if (fin_en) begin
                state_q <= ST_IDLE; done_q <= 1'b1; tr_q <= 1'b0; boot_q <= 1'b0;
                if (ie_q) irq_q <= 1'b1;
                if (fin_code != 8'h00) err_q <= 1'b1;
                esr_q <= fin_esr;
                if (fin_keep) dbr_q <= ecode_q;
                else begin ecode_q <= fin_code; dbr_q <= fin_esr; end
            end
            if (csr_wr) begin
                ie_q <= csr_new[CB_IE];
                if (!csr_new[CB_IE])          irq_q <= 1'b0;
                else if (done_q && !ie_q)     irq_q <= 1'b1;
            end
        end
    end

    assign bus_rdata  = bus_sel ? {8'h00, dbr_q}
                                : {err_q, 7'b0, tr_q, ie_q, done_q, 5'b0};
    assign irq        = irq_q;
    assign mem_req    = (state_q == ST_XFER);
    assign mem_we     = (func_q != FN_READ);
    assign mem_drive  = drv_q;
    assign mem_track  = trk_q;
    assign mem_sector = sec_q;
    assign mem_idx    = ptr_q[IW-1:0];
    assign mem_wdata  = buf_rd;
endmodule

// File: rtl/fdc_pio_seq_chk.sv
// Temporal properties of the floppy sequencer, bound to its internals.
module fdc_pio_seq_chk #(
    parameter int BYTES = 128,
    localparam int PW = $clog2(BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_sel,
    input logic          bus_byte,
    input logic          bus_hi,
    input logic [15:0]   bus_wdata,
    input logic          irq,
    input logic          mem_req,
    input logic          busy,
    input logic          in_empty,
    input logic          tr,
    input logic          done,
    input logic          ie,
    input logic [2:0]    func,
    input logic [PW-1:0] ptr
);
    logic init_bit;
    assign init_bit = bus_byte ? (bus_hi && bus_wdata[6]) : bus_wdata[14];

    p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && busy && !init_bit) |=> $stable(func));
    p_ptr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(BYTES));
    p_mem_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !tr && !done));
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !tr));
    p_irq_ie_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie);
    p_tr_gap_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && !(bus_byte && bus_hi) && busy && !in_empty && tr) |=> !tr);
endmodule

bind fdc_pio_seq fdc_pio_seq_chk #(.BYTES(BYTES)) chk_bind_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_byte(bus_byte), .bus_hi(bus_hi), .bus_wdata(bus_wdata), .irq(irq),
    .mem_req(mem_req), .busy(busy), .in_empty(state_q == fdc_pkg::ST_EMPTY),
    .tr(tr_q), .done(done_q), .ie(ie_q), .func(func_q), .ptr(ptr_q)
);

// File: tb/fdc_pio_seq_tb.sv
module fdc_pio_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0, bus_hi = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic irq;
    logic [1:0] drv_present = 2'b11, drv_wprot = 2'b00;
    logic mem_req, mem_we, mem_drive, mem_ack;
    logic [7:0] mem_track, mem_wdata, mem_rdata;
    logic [6:0] mem_sector, mem_idx;

    int checks = 0, errors = 0, cyc = 0, acks = 0;
    int m_drv = 0, m_trk = 0, m_sec = 0;
    logic [7:0] wcap [128];
    logic [7:0] img  [128];
    bit finished = 0;

    always #2 clk = ~clk;

    fdc_pio_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_byte(bus_byte), .bus_hi(bus_hi), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .drv_present(drv_present), .drv_wprot(drv_wprot),
        .mem_req(mem_req), .mem_we(mem_we), .mem_drive(mem_drive), .mem_track(mem_track),
        .mem_sector(mem_sector), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [7:0] pat(int d, int t, int s, int i);
        return 8'((i * 3) + (t * 5) + (s * 7) + (d * 11) + 1);
    endfunction

    assign mem_ack   = mem_req;
    assign mem_rdata = pat(int'(mem_drive), int'(mem_track), int'(mem_sector), int'(mem_idx));

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            acks <= acks + 1;
            m_drv <= int'(mem_drive); m_trk <= int'(mem_track); m_sec <= int'(mem_sector);
            if (mem_we) wcap[mem_idx] <= mem_wdata;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
            summary();
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic byt, logic hi, logic [15:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_byte = byt; bus_hi = hi; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b0; bus_hi = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic get(logic sel, output int v);
        bus_sel = sel; #1; v = int'(bus_rdata); bus_sel = 1'b0;
    endtask

    task automatic db_read(output int v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; #1; v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic wait_bit(int b);
        int v;
        for (int k = 0; k < 2000; k++) begin
            get(1'b0, v);
            if (v[b]) return;
            @(negedge clk);
        end
    endtask

    task automatic fill(input logic [7:0] src [128]);
        for (int i = 0; i < 128; i++) begin
            wait_bit(7);
            wr(1'b1, 1'b0, 1'b0, {8'h00, src[i]});
        end
        wait_bit(5);
    endtask

    task automatic empty_cmp(string tag, input logic [7:0] ref_b [128]);
        int v, bad;
        bad = 0;
        wr(1'b0, 1'b0, 1'b0, 16'h0003);
        for (int i = 0; i < 128; i++) begin
            wait_bit(7);
            db_read(v);
            if (v != int'(ref_b[i])) bad = bad + 1;
        end
        wait_bit(5);
        chk(tag, bad, 0);
    endtask

    task automatic rw_cmd(logic [15:0] go, logic [7:0] s, logic [7:0] t);
        wr(1'b0, 1'b0, 1'b0, go);
        wait_bit(7); wr(1'b1, 1'b0, 1'b0, {8'h00, s});
        wait_bit(7); wr(1'b1, 1'b0, 1'b0, {8'h00, t});
        wait_bit(5);
    endtask

    initial begin
        int v, a0;
        logic [7:0] ref_b [128];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        get(1'b0, v); chk("R1 csr", v, 0);
        get(1'b1, v); chk("R1 data", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 mem_req", int'(mem_req), 0);

        // R3/R2/R14 fill from drive 0 selection
        for (int i = 0; i < 128; i++) img[i] = 8'(i) ^ 8'hA5;
        wr(1'b0, 1'b0, 1'b0, 16'h0001);
        get(1'b0, v); chk("R2 csr read mask after fill start", v, 16'h0080);
        wr(1'b1, 1'b0, 1'b0, {8'h00, img[0]});
        get(1'b0, v); chk("R14 tr low after accept", v & 16'h80, 0);
        @(negedge clk);
        get(1'b0, v); chk("R14 tr back after delay", v & 16'h80, 16'h80);
        for (int i = 1; i < 128; i++) begin
            wait_bit(7);
            if (i == 40) wr(1'b0, 1'b0, 1'b0, 16'h0003);   // R2 start while busy ignored
            wr(1'b1, 1'b0, 1'b0, {8'h00, img[i]});
        end
        wait_bit(5);
        get(1'b0, v); chk("R3 done after 128 bytes", v, 16'h0020);
        get(1'b1, v); chk("R6 status in data word", v, 16'h80);

        // R4/R6 empty with interrupt enable
        for (int i = 0; i < 128; i++) ref_b[i] = img[i];
        wr(1'b0, 1'b0, 1'b0, 16'h0043);
        for (int i = 0; i < 128; i++) begin
            wait_bit(7); db_read(v);
            if (i == 0 || i == 127) chk("R4 empty byte", v, int'(img[i]));
        end
        wait_bit(5);
        chk("R6 irq with enable", int'(irq), 1);
        get(1'b0, v); chk("R6 csr done+ie", v, 16'h0060);

        // R12 enable-only writes
        wr(1'b0, 1'b0, 1'b0, 16'h0000);
        chk("R12 irq drop", int'(irq), 0);
        get(1'b0, v); chk("R12 done kept", v, 16'h0020);
        wr(1'b0, 1'b0, 1'b0, 16'h0040);
        chk("R12 irq raise", int'(irq), 1);
        wr(1'b0, 1'b0, 1'b0, 16'h0000);

        // R5 read drive 1, sector byte 0x85 keeps 5, track 10
        a0 = acks;
        rw_cmd(16'h0017, 8'h85, 8'd10);
        chk("R5 read meta drive", m_drv, 1);
        chk("R5 read meta track", m_trk, 10);
        chk("R5 read meta sector", m_sec, 5);
        chk("R5 read ack count", acks - a0, 128);
        get(1'b1, v); chk("R6 read status", v, 16'h80);
        for (int i = 0; i < 128; i++) ref_b[i] = pat(1, 10, 5, i);
        empty_cmp("R5 read buffer", ref_b);

        // R5 write drive 0 sector 3 track 76
        for (int i = 0; i < 128; i++) img[i] = ~8'(i * 7);
        wr(1'b0, 1'b0, 1'b0, 16'h0001); fill(img);
        rw_cmd(16'h0005, 8'd3, 8'd76);
        begin
            int bad; bad = 0;
            for (int i = 0; i < 128; i++) if (wcap[i] != img[i]) bad++;
            chk("R5 write data", bad, 0);
        end
        chk("R5 write meta", m_trk * 256 + m_sec, 76 * 256 + 3);

        // R7 error priority and codes, R9 read error code
        a0 = acks;
        rw_cmd(16'h0007, 8'd1, 8'd77);
        get(1'b0, v); chk("R7 track error flag", v, 16'h8020);
        wr(1'b0, 1'b0, 1'b0, 16'h000F); wait_bit(5);
        get(1'b1, v); chk("R9 code track", v, 16'h20);
        get(1'b0, v); chk("R9 no error on code read", v, 16'h0020);
        wr(1'b0, 1'b0, 1'b0, 16'h000F); wait_bit(5);
        get(1'b1, v); chk("R9 code unchanged", v, 16'h20);
        rw_cmd(16'h0007, 8'd0, 8'd5);
        wr(1'b0, 1'b0, 1'b0, 16'h000F); wait_bit(5);
        get(1'b1, v); chk("R7 sector 0", v, 16'h38);
        rw_cmd(16'h0007, 8'd27, 8'd200);
        wr(1'b0, 1'b0, 1'b0, 16'h000F); wait_bit(5);
        get(1'b1, v); chk("R7 track before sector", v, 16'h20);
        rw_cmd(16'h0007, 8'd27, 8'd5);
        wr(1'b0, 1'b0, 1'b0, 16'h000F); wait_bit(5);
        get(1'b1, v); chk("R7 sector 27", v, 16'h38);
        drv_present = 2'b01;
        rw_cmd(16'h0017, 8'd1, 8'd99);
        get(1'b1, v); chk("R7 absent status", v, 16'h00);
        wr(1'b0, 1'b0, 1'b0, 16'h001F); wait_bit(5);
        get(1'b1, v); chk("R7 absent code", v, 16'h48);
        drv_present = 2'b11;
        drv_wprot = 2'b01;
        rw_cmd(16'h0005, 8'd1, 8'd1);
        get(1'b1, v); chk("R7 protect status", v, 16'h88);
        wr(1'b0, 1'b0, 1'b0, 16'h000F); wait_bit(5);
        get(1'b1, v); chk("R7 protect code", v, 16'h40);
        chk("R7 no medium access on errors", acks - a0, 0);
        drv_wprot = 2'b00;

        // R8 deleted mark, R9 status read
        rw_cmd(16'h000D, 8'd2, 8'd2);
        get(1'b1, v); chk("R8 deleted mark status", v, 16'hC0);
        wr(1'b0, 1'b0, 1'b0, 16'h000B); wait_bit(5);
        get(1'b1, v); chk("R9 status function", v, 16'hC0);
        rw_cmd(16'h0007, 8'd1, 8'd1);
        get(1'b1, v); chk("R8 cleared on next read", v, 16'h80);

        // R11 ignored data writes
        for (int i = 0; i < 128; i++) img[i] = 8'(i + 16);
        wr(1'b0, 1'b0, 1'b0, 16'h0001);
        wait_bit(7);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = {8'h00, img[0]};
        @(negedge clk);
        bus_wdata = 16'h00EE;                     // lands while TR is low
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
        for (int i = 1; i < 128; i++) begin
            wait_bit(7); wr(1'b1, 1'b0, 1'b0, {8'h00, img[i]});
        end
        wait_bit(5);
        empty_cmp("R11 busy write ignored", img);
        wr(1'b1, 1'b0, 1'b0, 16'h003C);
        get(1'b1, v); chk("R11 idle store", v, 16'h3C);
        wr(1'b1, 1'b1, 1'b1, 16'h0055);
        get(1'b1, v); chk("R11 high lane ignored", v, 16'h3C);

        // R13 byte lanes
        wr(1'b0, 1'b1, 1'b0, 16'h0040);
        get(1'b0, v); chk("R13 low lane ie", v, 16'h0060);
        wr(1'b0, 1'b1, 1'b0, 16'h0000);
        wr(1'b0, 1'b1, 1'b1, 16'h0040);
        get(1'b0, v); chk("R13 high lane init clears done", v, 16'h0000);

        // R10 initialise
        wait_bit(5);
        get(1'b1, v); chk("R10 init status", v, 16'h84);
        get(1'b0, v); chk("R10 init csr", v, 16'h0020);
        for (int i = 0; i < 128; i++) ref_b[i] = pat(0, 1, 1, i);
        empty_cmp("R10 boot sector", ref_b);
        drv_present = 2'b10;
        wr(1'b0, 1'b0, 1'b0, 16'h4000);
        get(1'b0, v); chk("R10 absent csr", v, 16'h8020);
        get(1'b1, v); chk("R10 absent status", v, 16'h04);
        wr(1'b0, 1'b0, 1'b0, 16'h000F); wait_bit(5);
        get(1'b1, v); chk("R10 absent code", v, 16'h08);
        drv_present = 2'b11;

        summary();
    end
endmodule